// File: doc/BRIEF.md
# Gated Interval Timer Channel

A single down-counting timer channel with a 16-bit count register, one gate and one output. The gate is taken from a software control bit. It can also be taken from an external pin when that pin function is enabled. The channel output is always visible as a status bit and always drives an interrupt request line. It reaches the external output pin only while the output-enable input is set.

Software first writes a mode word and then a count. The channel has two modes. In terminal-count mode the output falls when a count is loaded. It rises after that many gated clocks and then stays high. In one-shot mode the loaded count only arms the channel. A rising edge of the gate starts a low pulse that lasts the loaded count in clocks. A further rising edge during the pulse reloads the count and lengthens the pulse.

Top module: `gated_interval_timer`

## Requirements
- R1: After reset, out_sts_o, irq_o and out_pin_o are low and the channel is in terminal-count mode with no count loaded.
- R2: The effective gate is sw_gate_i while gate_pin_en_i is low, and sw_gate_i OR gate_pin_i while gate_pin_en_i is high. A gate rising edge is a clock where the effective gate is high and was low on the previous clock.
- R3: irq_o always equals out_sts_o. out_pin_o equals out_sts_o while out_pin_en_i is high, and is low otherwise.
- R4: A mode write (mode_we_i, mode_sel_i 0 = terminal count, 1 = one-shot) sets the output on the next clock to low for terminal count and high for one-shot, and stops counting until a count is loaded. When a mode write and a count write occur together, the mode write wins and the count write is dropped.
- R5: In terminal-count mode, a count write drives the output low on the next clock and restarts counting from the written value.
- R6: In terminal-count mode the count decrements only on clocks where the effective gate is high and holds while it is low. With the gate held high, the output rises exactly N clocks after the clock that loads count N.
- R7: In terminal-count mode, once high, the output stays high until a new count or a mode word is written.
- R8: In one-shot mode a count write leaves the output unchanged. A gate rising edge, once a count has been loaded, drives the output low on that clock, and the output returns high exactly N clocks later.
- R9: In one-shot mode a gate rising edge during an active pulse reloads the count N, so the output rises N clocks after the latest trigger.
- R10: A count value of 0 is treated as 65536 clocks.
- R11: In one-shot mode the output stays high while the gate level is held steady. A gate rising edge after a mode word but before any count write has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_we_i | input | 1 | Mode word write strobe |
| mode_sel_i | input | 1 | Mode: 0 terminal count, 1 one-shot |
| count_we_i | input | 1 | Count write strobe |
| count_i | input | 16 | Count value to load |
| sw_gate_i | input | 1 | Software gate bit |
| gate_pin_en_i | input | 1 | Enables the external gate pin function |
| gate_pin_i | input | 1 | External gate pin |
| out_pin_en_i | input | 1 | Enables the output onto the external pin |
| out_sts_o | output | 1 | Channel output status |
| irq_o | output | 1 | Interrupt request line |
| out_pin_o | output | 1 | External output pin |

## Verification
Some rules hold on every cycle, and the embedded assertions check those. A count load in terminal-count mode pulls the output low. A held-low gate freezes the count. A high terminal-count output stays high until it is rewritten. A mode word sets the idle level. A one-shot trigger loads the stored count. Other behaviour depends on exact clock counts, and only the directed scenarios show it. This covers the N-clock terminal-count and one-shot pulse widths, the lengthened pulse after a retrigger, the 65536-clock zero count, the gate-pin selection and the dropping of early triggers.

// File: rtl/gated_interval_timer_pkg.sv
package gated_interval_timer_pkg;
  typedef enum logic {
    MODE_TERM    = 1'b0,
    MODE_ONESHOT = 1'b1
  } mode_e;
endpackage

// File: rtl/timer_gate_ctl.sv
module timer_gate_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_gate_i,
  input  logic gate_pin_en_i,
  input  logic gate_pin_i,
  output logic gate_o,
  output logic rise_o
);
  logic gate_q;

  assign gate_o = sw_gate_i | (gate_pin_en_i & gate_pin_i);
  assign rise_o = gate_o & ~gate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= gate_o;
  end

  // R2: a rising edge is never reported on two consecutive clocks
  assert_no_double_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/timer_count_core.sv
module timer_count_core
  import gated_interval_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_we_i,
  input  logic             mode_sel_i,
  input  logic             count_we_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             gate_i,
  input  logic             rise_i,
  output logic             out_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  mode_e            mode_q;
  logic [CNT_W-1:0] cnt_q, reload_q;
  logic             out_q, run_q, loaded_q;
  logic             last_tick;

  assign last_tick = (cnt_q == CNT_ONE);
  assign out_o     = out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_TERM;
      cnt_q    <= '0;
      reload_q <= '0;
      out_q    <= 1'b0;
      run_q    <= 1'b0;
      loaded_q <= 1'b0;
    end else if (mode_we_i) begin
      mode_q   <= mode_e'(mode_sel_i);
      out_q    <= (mode_e'(mode_sel_i) == MODE_ONESHOT);
      run_q    <= 1'b0;
      loaded_q <= 1'b0;
    end else begin
      if (count_we_i) begin
        reload_q <= count_i;
        loaded_q <= 1'b1;
      end
      if (mode_q == MODE_TERM) begin
        if (count_we_i) begin
          cnt_q <= count_i;
          out_q <= 1'b0;
          run_q <= 1'b1;
        end else if (run_q && gate_i) begin
          cnt_q <= cnt_q - CNT_ONE;  // zero wraps: full 2^CNT_W clocks
          if (last_tick) begin
            out_q <= 1'b1;
            run_q <= 1'b0;
          end
        end
      end else begin
        if (rise_i && loaded_q) begin
          cnt_q <= reload_q;  // trigger or retrigger
          out_q <= 1'b0;
          run_q <= 1'b1;
        end else if (run_q) begin
          cnt_q <= cnt_q - CNT_ONE;
          if (last_tick) begin
            out_q <= 1'b1;
            run_q <= 1'b0;
          end
        end
      end
    end
  end

  assert_mode_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_we_i |=> (out_q == $past(mode_sel_i)) && !run_q);

  assert_term_load_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_we_i && !mode_we_i && mode_q == MODE_TERM) |=> !out_q && run_q);

  assert_term_gate_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_TERM && !gate_i && !count_we_i && !mode_we_i) |=> $stable(cnt_q));

  assert_term_high_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_TERM && out_q && !count_we_i && !mode_we_i) |=> out_q);

  assert_oneshot_trigger_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_ONESHOT && rise_i && loaded_q && !mode_we_i)
      |=> !out_q && (cnt_q == $past(reload_q)));

  assert_oneshot_no_arm_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_ONESHOT && !loaded_q && out_q && !mode_we_i) |=> out_q);
endmodule

// File: rtl/gated_interval_timer.sv
module gated_interval_timer
  import gated_interval_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_we_i,
  input  logic             mode_sel_i,
  input  logic             count_we_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             sw_gate_i,
  input  logic             gate_pin_en_i,
  input  logic             gate_pin_i,
  input  logic             out_pin_en_i,
  output logic             out_sts_o,
  output logic             irq_o,
  output logic             out_pin_o
);
  logic gate, gate_rise, chan_out;

  timer_gate_ctl u_gate (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sw_gate_i     (sw_gate_i),
    .gate_pin_en_i (gate_pin_en_i),
    .gate_pin_i    (gate_pin_i),
    .gate_o        (gate),
    .rise_o        (gate_rise)
  );

  timer_count_core #(.CNT_W(CNT_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_we_i  (mode_we_i),
    .mode_sel_i (mode_sel_i),
    .count_we_i (count_we_i),
    .count_i    (count_i),
    .gate_i     (gate),
    .rise_i     (gate_rise),
    .out_o      (chan_out)
  );

  assign out_sts_o = chan_out;
  assign irq_o     = chan_out;
  assign out_pin_o = chan_out & out_pin_en_i;

  assert_pin_gated_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_pin_en_i |-> !out_pin_o);
endmodule

// File: tb/gated_interval_timer_tb_top.sv
module gated_interval_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_we = 1'b0, mode_sel = 1'b0, count_we = 1'b0;
  logic [15:0] count = '0;
  logic        sw_gate = 1'b0, gate_pin_en = 1'b0, gate_pin = 1'b0, out_pin_en = 1'b0;
  logic        out_sts, irq, out_pin;
  int          checks = 0, failures = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  gated_interval_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_we_i(mode_we), .mode_sel_i(mode_sel),
    .count_we_i(count_we), .count_i(count), .sw_gate_i(sw_gate),
    .gate_pin_en_i(gate_pin_en), .gate_pin_i(gate_pin), .out_pin_en_i(out_pin_en),
    .out_sts_o(out_sts), .irq_o(irq), .out_pin_o(out_pin)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_mode(logic sel);
    mode_sel = sel; mode_we = 1'b1;
    step(1);
    mode_we = 1'b0;
  endtask

  task automatic write_count(logic [15:0] v);
    count = v; count_we = 1'b1;
    step(1);
    count_we = 1'b0;
  endtask

  task automatic t_reset_r1();
    chk("R1", "out_sts after reset", out_sts, 1'b0);
    chk("R1", "irq after reset", irq, 1'b0);
    chk("R1", "out_pin after reset", out_pin, 1'b0);
  endtask

  task automatic t_term_basic_r5_r6();
    sw_gate = 1'b1;
    write_mode(1'b0);
    chk("R4", "term idle low", out_sts, 1'b0);
    write_count(16'd5);
    chk("R5", "out low after load", out_sts, 1'b0);
    step(4);
    chk("R6", "still low at N-1", out_sts, 1'b0);
    step(1);
    chk("R6", "high at N", out_sts, 1'b1);
    step(5);
    chk("R7", "stays high", out_sts, 1'b1);
    write_count(16'd3);
    chk("R5", "reload pulls low", out_sts, 1'b0);
    step(3);
    chk("R6", "high after 3", out_sts, 1'b1);
    write_mode(1'b0);
    chk("R7", "mode word clears high", out_sts, 1'b0);
  endtask

  task automatic t_term_gate_hold_r6();
    sw_gate = 1'b0;
    write_count(16'd4);
    step(10);
    chk("R6", "gate low holds", out_sts, 1'b0);
    sw_gate = 1'b1;
    step(3);
    chk("R6", "3 gated clocks low", out_sts, 1'b0);
    step(1);
    chk("R6", "4th gated clock high", out_sts, 1'b1);
  endtask

  task automatic t_output_routing_r3();
    out_pin_en = 1'b0;
    step(1);
    chk("R3", "pin off when disabled", out_pin, 1'b0);
    chk("R3", "irq follows status", irq, out_sts);
    out_pin_en = 1'b1;
    step(1);
    chk("R3", "pin on when enabled", out_pin, 1'b1);
    write_count(16'd8);
    chk("R3", "pin follows low", out_pin, 1'b0);
    chk("R3", "irq follows low", irq, 1'b0);
  endtask

  task automatic t_oneshot_r8_r11();
    sw_gate = 1'b0;
    write_mode(1'b1);
    chk("R4", "oneshot idle high", out_sts, 1'b1);
    sw_gate = 1'b1;
    step(3);
    chk("R11", "trigger before load ignored", out_sts, 1'b1);
    sw_gate = 1'b0;
    step(1);
    write_count(16'd3);
    chk("R8", "load keeps high", out_sts, 1'b1);
    sw_gate = 1'b1;
    step(1);
    chk("R8", "trigger drives low", out_sts, 1'b0);
    step(2);
    chk("R8", "low at N-1", out_sts, 1'b0);
    step(1);
    chk("R8", "high after N", out_sts, 1'b1);
    step(6);
    chk("R11", "held gate no retrigger", out_sts, 1'b1);
  endtask

  task automatic t_retrigger_r9();
    sw_gate = 1'b0;
    write_count(16'd6);
    step(1);
    sw_gate = 1'b1;
    step(1);
    chk("R9", "first trigger low", out_sts, 1'b0);
    step(2);
    sw_gate = 1'b0;
    step(1);
    sw_gate = 1'b1;
    step(1);  // retrigger edge, 4 clocks after first
    step(2);
    chk("R9", "past original end still low", out_sts, 1'b0);
    step(3);
    chk("R9", "low at 5 after retrigger", out_sts, 1'b0);
    step(1);
    chk("R9", "high 6 after retrigger", out_sts, 1'b1);
  endtask

  task automatic t_gate_pin_r2();
    sw_gate = 1'b0; gate_pin = 1'b0; gate_pin_en = 1'b0;
    write_count(16'd2);
    step(1);
    gate_pin = 1'b1;
    step(3);
    chk("R2", "pin ignored when disabled", out_sts, 1'b1);
    gate_pin = 1'b0;
    gate_pin_en = 1'b1;
    step(1);
    gate_pin = 1'b1;
    step(1);
    chk("R2", "pin triggers when enabled", out_sts, 1'b0);
    step(2);
    chk("R2", "pin-triggered pulse ends", out_sts, 1'b1);
    gate_pin = 1'b0; gate_pin_en = 1'b0;
  endtask

  task automatic t_mode_priority_r4();
    mode_sel = 1'b1; mode_we = 1'b1;
    count = 16'd2; count_we = 1'b1;
    step(1);
    mode_we = 1'b0; count_we = 1'b0;
    chk("R4", "mode wins, idle high", out_sts, 1'b1);
    step(1);
    sw_gate = 1'b1;
    step(4);
    chk("R4", "dropped count leaves channel unarmed", out_sts, 1'b1);
    sw_gate = 1'b0;
  endtask

  task automatic t_zero_count_r10();
    sw_gate = 1'b1;
    write_mode(1'b0);
    write_count(16'd0);
    step(65535);
    chk("R10", "low at 65535", out_sts, 1'b0);
    step(1);
    chk("R10", "high at 65536", out_sts, 1'b1);
  endtask

  initial begin
    step(2);
    t_reset_r1();
    rst_n = 1'b1;
    step(1);
    t_term_basic_r5_r6();
    t_term_gate_hold_r6();
    t_output_routing_r3();
    t_oneshot_r8_r11();
    t_retrigger_r9();
    t_gate_pin_r2();
    t_mode_priority_r4();
    t_zero_count_r10();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule